// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense and Aggregation

This block turns the synchronised input levels of one GPIO bank into interrupt requests. For every pin it detects a configurable condition: a rising edge, a falling edge, any edge, a high level or a low level. When the condition is detected, it sets a sticky status bit for that pin. Software clears status bits through per-port write-one-to-clear strobes. Each status bit is qualified by a per-pin enable, and the qualified bits are ORed into one registered interrupt line for the whole bank.

The bank is organised as ports of pins, four ports of eight pins by default. The sense configuration is supplied as one packed word per port holding three fields: polarity, edge select and any-edge select. Bus decode, register storage and pad control sit outside this block. The configuration and enable vectors come from registers held elsewhere, and the clear arrives as a strobe with a port index and a bit mask.

Edge detection compares each pin's level with its level on the previous cycle. The comparison is only trusted once one cycle has passed since reset. Because software clears an edge status before it services the event, a new event in the same cycle as a clear of that bit must not be lost.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin index is port*8+n. Port p's configuration occupies trig_cfg[p*24 +: 24]. Within that field, bit n is polarity, bit 8+n is edge select and bit 16+n is any-edge select. With edge=1, any-edge=0 and polarity=1, status[i] becomes 1 on the clock edge at which pin_lvl[i] is 1 and was 0 on the previous cycle.
- R2: With edge=1, any-edge=0 and polarity=0, status sets on a 1-to-0 transition of the pin, and a 0-to-1 transition sets nothing.
- R3: With edge=1 and any-edge=1, status sets on a transition in either direction, whatever the polarity bit.
- R4: With edge=0, status sets on every clock edge where the pin equals the polarity bit (1 means level high, 0 means level low). The any-edge bit has no effect in this case.
- R5: A clear strobe with port index p and mask m clears status[p*8+n] for each bit n set in m. Zero mask bits and other ports are unaffected. Status bits not cleared keep their value.
- R6: When an event is detected in the same cycle as a clear of that bit, the bit ends up set.
- R7: In level mode, a clear has no lasting effect while the active level persists. Once the level is inactive, the clear drops the bit.
- R8: irq is 1 one cycle after any status bit is 1 while its irq_en bit is 1, and 0 otherwise. A disabled pin does not raise irq, but its status is still recorded.
- R9: During reset, and right after it, status is all zero and irq is 0. No edge is detected on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pin_lvl | input | 32 | Synchronised pin levels |
| trig_cfg | input | 96 | Per-port sense configuration: polarity, edge and any-edge fields |
| irq_en | input | 32 | Per-pin interrupt enable |
| clr_stb | input | 1 | Clear strobe, valid for one cycle |
| clr_port | input | 2 | Port addressed by the clear |
| clr_mask | input | 8 | Write-one-to-clear bit mask for that port |
| status | output | 32 | Sticky status readback |
| irq | output | 1 | Registered bank interrupt, active high |

## Verification
The assertions assume that the pin levels are already synchronised and change only between clock edges. They also assume that the configuration and enable vectors are stable values rather than X, and that a clear names a port that exists in the bank. The stimulus changes pins, configuration and enables only at the falling clock edge. Clear ports are drawn from the implemented range, and pin toggles are sparse enough that edge, level and clear collisions all occur without the pins becoming noise.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

   // Number of configuration fields packed per port
   localparam int unsigned SENSE_FIELDS = 3;

   typedef enum logic [2:0] {
      SNS_LVL_LOW  = 3'd0,
      SNS_LVL_HIGH = 3'd1,
      SNS_FALL     = 3'd2,
      SNS_RISE     = 3'd3,
      SNS_ANY_EDGE = 3'd4
   } sense_e;

   // Turn the three raw configuration bits of one pin into a sense mode.
   // The any-edge bit only matters when edge select is set.
   function automatic sense_e decode_sense(input logic pol, input logic edg,
                                           input logic any);
      sense_e m;
      if (!edg)
         m = pol ? SNS_LVL_HIGH : SNS_LVL_LOW;
      else if (any)
         m = SNS_ANY_EDGE;
      else
         m = pol ? SNS_RISE : SNS_FALL;
      return m;
   endfunction

endpackage

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
module gpio_irq_sense
   import gpio_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic primed,
   input  logic lvl,
   input  logic pol,
   input  logic edg,
   input  logic any,
   output logic evt
);

   logic   prev_q;
   logic   rise;
   logic   fall;
   sense_e mode;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = primed &  lvl & ~prev_q;
   assign fall = primed & ~lvl &  prev_q;
   assign mode = decode_sense(pol, edg, any);

   always_comb begin
      unique case (mode)
         SNS_LVL_LOW:  evt = ~lvl;
         SNS_LVL_HIGH: evt = lvl;
         SNS_FALL:     evt = fall;
         SNS_RISE:     evt = rise;
         SNS_ANY_EDGE: evt = rise | fall;
         default:      evt = 1'b0;
      endcase
   end

   // R9: edge reference not yet valid, no edge event may appear
   p_no_edge_unprimed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!primed && edg) |-> !evt);

   // R3: an edge-mode event needs the level to differ from last cycle
   p_edge_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edg && evt) |-> (lvl != prev_q));

endmodule

// File: rtl/gpio_irq_clr_decode.sv
`timescale 1ns/1ps
module gpio_irq_clr_decode #(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned PORT_PINS = 8,
   localparam int unsigned NPIN     = NUM_PORTS * PORT_PINS,
   localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clr_stb,
   input  logic [PORT_W-1:0]    clr_port,
   input  logic [PORT_PINS-1:0] clr_mask,
   output logic [NPIN-1:0]      clr_vec
);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = clr_stb && (clr_port == PORT_W'(p));
      assign clr_vec[p*PORT_PINS +: PORT_PINS] = hit ? clr_mask : '0;
   end

endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
   parameter int unsigned NPIN    = 32,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] set_vec,
   input  logic [NPIN-1:0] clr_vec,
   input  logic [NPIN-1:0] en,
   output logic [NPIN-1:0] status,
   output logic            irq
);

   logic [NPIN-1:0] sts_q;
   logic            pend;

   // Set has priority over clear for the same bit
   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_vec) | set_vec;
   end

   assign status = sts_q;
   assign pend   = |(sts_q & en);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq = irq_q;

      // R8: the line follows the qualified status one cycle later
      p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(status & en))));
   end else begin : g_irq_comb
      assign irq = pend;
   end

   // R5: a cleared bit with no competing event reads 0 afterwards
   p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_vec & ~set_vec)) |=> ((status & $past(clr_vec & ~set_vec)) == '0));

   // R5: bits not addressed by a clear keep a 1
   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(status) & ~$past(clr_vec)) & ~status) == '0));

   // R6: every detected event shows up as a 1, clear or not
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned PORT_PINS = 8,
   parameter bit          IRQ_REG   = 1'b1,
   localparam int unsigned NPIN     = NUM_PORTS * PORT_PINS,
   localparam int unsigned FIELD_W  = SENSE_FIELDS * PORT_PINS,
   localparam int unsigned CFG_W    = NUM_PORTS * FIELD_W,
   localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPIN-1:0]      pin_lvl,
   input  logic [CFG_W-1:0]     trig_cfg,
   input  logic [NPIN-1:0]      irq_en,
   input  logic                 clr_stb,
   input  logic [PORT_W-1:0]    clr_port,
   input  logic [PORT_PINS-1:0] clr_mask,
   output logic [NPIN-1:0]      status,
   output logic                 irq
);

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("gpio_irq_bank: NUM_PORTS must be at least 1");
   end
   if (PORT_PINS < 1) begin : g_bad_pins
      $error("gpio_irq_bank: PORT_PINS must be at least 1");
   end

   logic            primed_q;
   logic [NPIN-1:0] evt_vec;
   logic [NPIN-1:0] clr_vec;

   // Edge reference becomes valid one cycle after reset
   always_ff @(posedge clk) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      for (genvar n = 0; n < PORT_PINS; n++) begin : g_pin
         localparam int unsigned IDX  = p * PORT_PINS + n;
         localparam int unsigned BASE = p * FIELD_W;
         gpio_irq_sense i_sense (
            .clk    (clk),
            .rst_n  (rst_n),
            .primed (primed_q),
            .lvl    (pin_lvl[IDX]),
            .pol    (trig_cfg[BASE + n]),
            .edg    (trig_cfg[BASE + PORT_PINS + n]),
            .any    (trig_cfg[BASE + 2*PORT_PINS + n]),
            .evt    (evt_vec[IDX])
         );
      end
   end

   gpio_irq_clr_decode #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_PINS (PORT_PINS)
   ) i_clr (
      .clr_stb  (clr_stb),
      .clr_port (clr_port),
      .clr_mask (clr_mask),
      .clr_vec  (clr_vec)
   );

   gpio_irq_status #(
      .NPIN    (NPIN),
      .IRQ_REG (IRQ_REG)
   ) i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (evt_vec),
      .clr_vec (clr_vec),
      .en      (irq_en),
      .status  (status),
      .irq     (irq)
   );

   // R9: the first edge after reset release leaves status and irq idle
   p_reset_idle_r9: assert property (@(posedge clk)
      $rose(rst_n) |-> (status == '0 && irq == 1'b0));

endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;

   localparam int NP = 4;
   localparam int PP = 8;
   localparam int N  = NP * PP;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  pin_lvl;
   logic [3*N-1:0] trig_cfg;
   logic [N-1:0]  irq_en;
   logic          clr_stb;
   logic [1:0]    clr_port;
   logic [PP-1:0] clr_mask;
   logic [N-1:0]  status;
   logic          irq;

   always #4 clk = ~clk;

   gpio_irq_bank i_gpio_irq_bank (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_cfg(trig_cfg),
      .irq_en(irq_en), .clr_stb(clr_stb), .clr_port(clr_port),
      .clr_mask(clr_mask), .status(status), .irq(irq)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // mode codes: 0 lvl low, 1 lvl high, 2 fall, 3 rise, 4 any edge,
   // 5 level high with any-edge bit set
   int mode [N];

   logic [N-1:0] m_stat, m_prev;
   logic         m_primed, m_irq;

   function automatic logic [2:0] mode_bits(input int md); // {any,edg,pol}
      case (md)
         0: return 3'b000;
         1: return 3'b001;
         2: return 3'b010;
         3: return 3'b011;
         4: return 3'b110;
         default: return 3'b101;
      endcase
   endfunction

   function automatic logic [3*N-1:0] build_cfg();
      logic [3*N-1:0] c = '0;
      for (int i = 0; i < N; i++) begin
         logic [2:0] b = mode_bits(mode[i]);
         int p = i / PP;
         int n = i % PP;
         c[p*24 + n]      = b[0];
         c[p*24 + 8 + n]  = b[1];
         c[p*24 + 16 + n] = b[2];
      end
      return c;
   endfunction

   function automatic logic want_evt(input logic [2:0] b, input logic l,
                                     input logic p, input logic pr);
      if (!b[1]) return (l == b[0]);
      if (!pr)   return 1'b0;
      if (b[2])  return (l != p);
      return b[0] ? (l & ~p) : (~l & p);
   endfunction

   task automatic set_modes(input int md);
      for (int i = 0; i < N; i++) mode[i] = md;
      trig_cfg = build_cfg();
   endtask

   task automatic chk_status(input string tag);
      n_chk++;
      if (status !== m_stat) begin
         n_fail++;
         $display("FAIL %s status actual=%h expected=%h", tag, status, m_stat);
      end
   endtask

   task automatic chk_irq(input string tag);
      n_chk++;
      if (irq !== m_irq) begin
         n_fail++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
      end
   endtask

   task automatic chk_bit(input string tag, input int idx, input logic exp);
      n_chk++;
      if (status[idx] !== exp) begin
         n_fail++;
         $display("FAIL %s status[%0d] actual=%b expected=%b", tag, idx,
                  status[idx], exp);
      end
   endtask

   task automatic chk_irq_lit(input string tag, input logic exp);
      n_chk++;
      if (irq !== exp) begin
         n_fail++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
      end
   endtask

   // Called at the falling edge with inputs already set
   task automatic tick(input string tag);
      logic [N-1:0] cv, ev, ns;
      logic         ni;
      cv = '0;
      if (clr_stb) cv[clr_port*PP +: PP] = clr_mask;
      for (int i = 0; i < N; i++)
         ev[i] = want_evt(mode_bits(mode[i]), pin_lvl[i], m_prev[i], m_primed);
      ns = (m_stat & ~cv) | ev;
      ni = |(m_stat & irq_en);
      @(posedge clk);
      m_stat = ns; m_irq = ni; m_prev = pin_lvl; m_primed = 1'b1;
      @(negedge clk);
      chk_status(tag);
      chk_irq(tag);
      clr_stb = 1'b0;
   endtask

   task automatic do_reset(input int md, input logic [N-1:0] lv);
      rst_n = 1'b0; clr_stb = 1'b0; clr_port = '0; clr_mask = '0;
      irq_en = '1; pin_lvl = lv; set_modes(md);
      repeat (3) @(negedge clk);
      m_stat = '0; m_prev = '0; m_primed = 1'b0; m_irq = 1'b0;
      chk_status("R9 in reset");
      chk_irq("R9 in reset");
      rst_n = 1'b1;
   endtask

   task automatic clear(input int p, input logic [PP-1:0] m);
      clr_stb = 1'b1; clr_port = 2'(p); clr_mask = m;
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);

      // R9 and R1: pins high at release, rising mode: no event yet
      do_reset(3, '1);
      tick("R9 first edge");
      chk_bit("R9 first edge", 0, 1'b0);
      tick("R9 hold");
      pin_lvl[0] = 1'b0; tick("R1 low");
      pin_lvl[0] = 1'b1; tick("R1 rise");
      chk_bit("R1 rise", 0, 1'b1);
      chk_bit("R1 other pin", 1, 1'b0);

      // R2 falling
      do_reset(2, '0);
      tick("R2 idle");
      pin_lvl[9] = 1'b1; tick("R2 rise ignored");
      chk_bit("R2 rise ignored", 9, 1'b0);
      pin_lvl[9] = 1'b0; tick("R2 fall");
      chk_bit("R2 fall", 9, 1'b1);

      // R3 any edge
      do_reset(4, '0);
      tick("R3 idle");
      pin_lvl[20] = 1'b1; tick("R3 up");
      chk_bit("R3 up", 20, 1'b1);
      clear(2, 8'h10); tick("R3 clear");
      chk_bit("R3 clear", 20, 1'b0);
      pin_lvl[20] = 1'b0; tick("R3 down");
      chk_bit("R3 down", 20, 1'b1);

      // R4 and R7 level modes
      do_reset(0, '1);
      tick("R4 idle");
      mode[12] = 5; trig_cfg = build_cfg(); tick("R4 any bit ignored");
      chk_bit("R4 any bit ignored", 12, 1'b1);
      mode[3] = 1; trig_cfg = build_cfg(); tick("R4 level high");
      chk_bit("R4 level high", 3, 1'b1);
      pin_lvl[30] = 1'b0; tick("R4 level low");
      chk_bit("R4 level low", 30, 1'b1);
      clear(0, 8'h08); tick("R7 clear while active");
      chk_bit("R7 clear while active", 3, 1'b1);
      pin_lvl[3] = 1'b0; tick("R7 inactive");
      clear(0, 8'h08); tick("R7 clear after inactive");
      chk_bit("R7 clear after inactive", 3, 1'b0);

      // R6 set wins, R5 masks and ports
      do_reset(3, '0);
      tick("R6 idle");
      pin_lvl[5] = 1'b1; clear(0, 8'h20); tick("R6 collide");
      chk_bit("R6 collide", 5, 1'b1);
      clear(0, 8'h00); tick("R5 zero mask");
      chk_bit("R5 zero mask", 5, 1'b1);
      clear(1, 8'h20); tick("R5 other port");
      chk_bit("R5 other port", 5, 1'b1);
      clear(0, 8'h20); tick("R5 clear");
      chk_bit("R5 clear", 5, 1'b0);

      // R8 enable qualification
      do_reset(3, '0);
      irq_en = '0;
      tick("R8 idle");
      pin_lvl[7] = 1'b1; tick("R8 event");
      tick("R8 masked");
      chk_bit("R8 recorded", 7, 1'b1);
      chk_irq_lit("R8 masked", 1'b0);
      irq_en[7] = 1'b1; tick("R8 enabled");
      chk_irq_lit("R8 enabled", 1'b1);
      irq_en[7] = 1'b0; tick("R8 disabled");
      chk_irq_lit("R8 disabled", 1'b0);

      // Random mix
      do_reset(0, '0);
      for (int c = 0; c < 4000; c++) begin
         if (c % 500 == 0) begin
            for (int i = 0; i < N; i++) mode[i] = int'($urandom_range(0, 5));
            trig_cfg = build_cfg();
         end
         pin_lvl = pin_lvl ^ ($urandom & $urandom & $urandom);
         if (c % 37 == 0) irq_en = $urandom;
         if ($urandom_range(0, 3) == 0)
            clear(int'($urandom_range(0, 3)), 8'($urandom));
         tick("R1 R2 R3 R4 R5 R6 R8 random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule